// File: doc/BRIEF.md
# Match-Code Address Translation Unit

This block relocates CPU addresses through a parameterised bank of container register sets. Every set holds three words: a mask word, a compare word and an offset/control word. The low byte of each word belongs to the mode match code or to a control byte. The remaining upper bits, from bit 8 up, belong to the address path.

A set takes part in translation only when the current 8-bit mode match code, masked by the set's match-code mask, equals the set's match-code compare byte. A taking-part set hits when the masked CPU address equals its address compare field. The hitting set then relocates the address: the masked bits are cleared and the offset field is ORed in. When several sets hit, the lowest-numbered one wins. When none hits, the address passes through.

Translation is purely combinational. The set registers are loaded through a simple synchronous write port, and the number of sets is presented as a constant configuration output. The block has no state machine. Its only state is the register bank, which has two conditions: cleared (after reset) and programmed (after writes).

Top module: `xlat_unit`

## Requirements
- R1: Set k is selected only when (match_code_i AND mask word bits 7:0) equals compare word bits 7:0 of set k.
- R2: A selected set hits when (cpu_addr_i AND address mask) equals the address compare value. The address mask is mask word bits 31:8 with bits 7:0 taken as zero. The compare value is compare word bits 31:8 with bits 7:0 taken as zero.
- R3: On a hit, xl_addr_o = (cpu_addr_i AND NOT address mask) OR address offset. The address offset is offset/control word bits 31:8 with bits 7:0 taken as zero.
- R4: ctrl_o equals bits 7:0 of the winning set's offset/control word, and is 0 when hit_o is low.
- R5: When several sets hit, the lowest-numbered set determines xl_addr_o and ctrl_o.
- R6: When no set hits, hit_o is 0 and xl_addr_o equals cpu_addr_i.
- R7: xl_addr_o[7:0] always equals cpu_addr_i[7:0].
- R8: A write with wr_en_i high loads wr_data_i into set wr_set_i at the next rising clock edge. The word is chosen by wr_sel_i: 0 = mask word, 1 = compare word, 2 = offset/control word. A write with wr_sel_i = 3 has no effect. Outputs follow the address and match-code inputs with no clock delay.
- R9: Reset clears every word of every set. Afterwards every set matches and hits, so set 0 wins: hit_o = 1, xl_addr_o = cpu_addr_i and ctrl_o = 0.
- R10: set_count_o presents the number of sets, NUM_SETS. NUM_SETS is at least 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the register write port |
| rst_n | input | 1 | Asynchronous active-low reset, clears all sets |
| cpu_addr_i | input | 32 | Untranslated CPU address |
| match_code_i | input | 8 | Current mode match code |
| wr_en_i | input | 1 | Register write strobe |
| wr_set_i | input | 2 | Index of the set to write |
| wr_sel_i | input | 2 | Word select: 0 mask, 1 compare, 2 offset/control, 3 none |
| wr_data_i | input | 32 | Write data |
| xl_addr_o | output | 32 | Translated address |
| hit_o | output | 1 | A set hit this address |
| ctrl_o | output | 8 | Control byte of the winning set |
| set_count_o | output | 8 | Number of container sets |

## Verification
The translated address, hit flag and control byte are due in the same cycle as the address and match code, with no register on the way. The bench therefore drives those inputs at a falling edge and samples them one nanosecond later, before any rising edge. A register write becomes visible only after the rising edge that follows the strobe. For a write, the bench samples once before that edge, to confirm the old value still holds, and once at the next falling edge, to confirm the new value.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
    localparam int MC_W  = 8;
    localparam int CNT_W = 8;

    typedef enum logic [1:0] {
        SEL_MASK = 2'd0,
        SEL_CMP  = 2'd1,
        SEL_OFFC = 2'd2,
        SEL_NONE = 2'd3
    } word_sel_e;
endpackage

// File: rtl/xlat_regbank.sv
module xlat_regbank
    import xlat_pkg::*;
#(
    parameter int NUM_SETS = 4,
    parameter int AW       = 32,
    localparam int SIDX_W  = $clog2(NUM_SETS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [SIDX_W-1:0] wr_set_i,
    input  logic [1:0]        wr_sel_i,
    input  logic [AW-1:0]     wr_data_i,
    output logic [AW-1:0]     mask_o [NUM_SETS],
    output logic [AW-1:0]     cmp_o  [NUM_SETS],
    output logic [AW-1:0]     offc_o [NUM_SETS]
);
    logic [AW-1:0] mask_q [NUM_SETS];
    logic [AW-1:0] cmp_q  [NUM_SETS];
    logic [AW-1:0] offc_q [NUM_SETS];

    for (genvar k = 0; k < NUM_SETS; k++) begin : g_set
        logic hit_wr;
        assign hit_wr = wr_en_i && (int'(wr_set_i) == k);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mask_q[k] <= '0;
                cmp_q[k]  <= '0;
                offc_q[k] <= '0;
            end else if (hit_wr) begin
                unique case (word_sel_e'(wr_sel_i))
                    SEL_MASK: mask_q[k] <= wr_data_i;
                    SEL_CMP:  cmp_q[k]  <= wr_data_i;
                    SEL_OFFC: offc_q[k] <= wr_data_i;
                    SEL_NONE: ;
                endcase
            end
        end

        assign mask_o[k] = mask_q[k];
        assign cmp_o[k]  = cmp_q[k];
        assign offc_o[k] = offc_q[k];
    end

    // R8
    mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_sel_i == SEL_MASK && int'(wr_set_i) < NUM_SETS)
        |=> mask_q[$past(wr_set_i)] == $past(wr_data_i));

    // R8
    offc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_sel_i == SEL_OFFC && int'(wr_set_i) < NUM_SETS)
        |=> offc_q[$past(wr_set_i)] == $past(wr_data_i));
endmodule

// File: rtl/xlat_set_match.sv
module xlat_set_match
    import xlat_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0]   addr_i,
    input  logic [MC_W-1:0] code_i,
    input  logic [AW-1:0]   mask_i,
    input  logic [AW-1:0]   cmp_i,
    output logic            hit_o
);
    logic [AW-1:0] amask;
    logic [AW-1:0] acmp;
    logic          code_ok;
    logic          addr_ok;

    always_comb begin
        amask   = {mask_i[AW-1:MC_W], {MC_W{1'b0}}};
        acmp    = {cmp_i[AW-1:MC_W], {MC_W{1'b0}}};
        code_ok = (code_i & mask_i[MC_W-1:0]) == cmp_i[MC_W-1:0];
        addr_ok = (addr_i & amask) == acmp;
        hit_o   = code_ok && addr_ok;
    end
endmodule

// File: rtl/xlat_prio.sv
module xlat_prio #(
    parameter int NUM_SETS = 4,
    localparam int SIDX_W  = $clog2(NUM_SETS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_SETS-1:0] req_i,
    output logic [NUM_SETS-1:0] grant_o,
    output logic [SIDX_W-1:0]   idx_o,
    output logic                any_o
);
    always_comb begin
        grant_o = '0;
        idx_o   = '0;
        any_o   = 1'b0;
        for (int k = NUM_SETS - 1; k >= 0; k--) begin
            if (req_i[k]) begin
                grant_o = '0;
                grant_o[k] = 1'b1;
                idx_o   = SIDX_W'(k);
                any_o   = 1'b1;
            end
        end
    end

    // R5
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o) && ((|req_i) == (|grant_o)));

    // R5
    grant_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((req_i & (grant_o - 1'b1)) == '0));
endmodule

// File: rtl/xlat_unit.sv
module xlat_unit
    import xlat_pkg::*;
#(
    parameter int NUM_SETS = 4,
    parameter int AW       = 32,
    localparam int SIDX_W  = $clog2(NUM_SETS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     cpu_addr_i,
    input  logic [MC_W-1:0]   match_code_i,
    input  logic              wr_en_i,
    input  logic [SIDX_W-1:0] wr_set_i,
    input  logic [1:0]        wr_sel_i,
    input  logic [AW-1:0]     wr_data_i,
    output logic [AW-1:0]     xl_addr_o,
    output logic              hit_o,
    output logic [MC_W-1:0]   ctrl_o,
    output logic [CNT_W-1:0]  set_count_o
);
    if (NUM_SETS < 4) begin : g_size_bad
        $error("xlat_unit needs at least four sets");
    end

    logic [AW-1:0]       mask_w [NUM_SETS];
    logic [AW-1:0]       cmp_w  [NUM_SETS];
    logic [AW-1:0]       offc_w [NUM_SETS];
    logic [NUM_SETS-1:0] set_hit;
    logic [NUM_SETS-1:0] grant;
    logic [SIDX_W-1:0]   win_idx;
    logic                any_hit;

    xlat_regbank #(.NUM_SETS(NUM_SETS), .AW(AW)) regbank_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_set_i  (wr_set_i),
        .wr_sel_i  (wr_sel_i),
        .wr_data_i (wr_data_i),
        .mask_o    (mask_w),
        .cmp_o     (cmp_w),
        .offc_o    (offc_w)
    );

    for (genvar k = 0; k < NUM_SETS; k++) begin : g_match
        xlat_set_match #(.AW(AW)) match_i (
            .addr_i (cpu_addr_i),
            .code_i (match_code_i),
            .mask_i (mask_w[k]),
            .cmp_i  (cmp_w[k]),
            .hit_o  (set_hit[k])
        );
    end

    xlat_prio #(.NUM_SETS(NUM_SETS)) prio_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (set_hit),
        .grant_o (grant),
        .idx_o   (win_idx),
        .any_o   (any_hit)
    );

    logic [AW-1:0] win_amask;
    logic [AW-1:0] win_aoff;

    always_comb begin
        win_amask = {mask_w[win_idx][AW-1:MC_W], {MC_W{1'b0}}};
        win_aoff  = {offc_w[win_idx][AW-1:MC_W], {MC_W{1'b0}}};
        if (any_hit) begin
            xl_addr_o = (cpu_addr_i & ~win_amask) | win_aoff;
            ctrl_o    = offc_w[win_idx][MC_W-1:0];
        end else begin
            xl_addr_o = cpu_addr_i;
            ctrl_o    = '0;
        end
        hit_o       = any_hit;
        set_count_o = CNT_W'(NUM_SETS);
    end

    // R7
    low_byte_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xl_addr_o[MC_W-1:0] == cpu_addr_i[MC_W-1:0]);

    // R6
    miss_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_o |-> (xl_addr_o == cpu_addr_i));

    // R4
    miss_ctrl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_o |-> (ctrl_o == '0));

    // R10
    set_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(set_count_o) == NUM_SETS);
endmodule

// File: tb/xlat_unit_tb_top.sv
`timescale 1ns/1ps
module xlat_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cpu_addr_i = '0;
    logic [7:0]  match_code_i = '0;
    logic        wr_en_i = 1'b0;
    logic [1:0]  wr_set_i = '0;
    logic [1:0]  wr_sel_i = '0;
    logic [31:0] wr_data_i = '0;
    logic [31:0] xl_addr_o;
    logic        hit_o;
    logic [7:0]  ctrl_o;
    logic [7:0]  set_count_o;

    int applied = 0;
    int miscompares = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    xlat_unit dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .cpu_addr_i   (cpu_addr_i),
        .match_code_i (match_code_i),
        .wr_en_i      (wr_en_i),
        .wr_set_i     (wr_set_i),
        .wr_sel_i     (wr_sel_i),
        .wr_data_i    (wr_data_i),
        .xl_addr_o    (xl_addr_o),
        .hit_o        (hit_o),
        .ctrl_o       (ctrl_o),
        .set_count_o  (set_count_o)
    );

    // {code, addr, exp_addr, exp_hit, exp_ctrl}
    localparam int NV = 7;
    localparam logic [80:0] VEC [NV] = '{
        {8'h21, 32'h1234_5678, 32'hA004_5678, 1'b1, 8'h11}, // R1 R5 set0 over set1
        {8'h20, 32'h1234_5678, 32'h5534_5678, 1'b1, 8'h22}, // R1 R3 set1
        {8'h77, 32'h1234_5678, 32'h1234_5778, 1'b1, 8'h33}, // R2 zero addr mask
        {8'h00, 32'h7123_4567, 32'h0923_4567, 1'b1, 8'h44}, // R3 set3
        {8'h00, 32'h1234_5678, 32'h1234_5678, 1'b0, 8'h00}, // R6 miss
        {8'h21, 32'h7123_4567, 32'h0923_4567, 1'b1, 8'h44}, // R2 R5 addr misses set0/1
        {8'h21, 32'h12FF_FF01, 32'h55FF_FF01, 1'b1, 8'h22}  // R2 set1 only
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        applied++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] set, input logic [1:0] sel, input logic [31:0] data);
        wr_en_i = 1'b1; wr_set_i = set; wr_sel_i = sel; wr_data_i = data;
        @(posedge clk); @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic drive(input logic [7:0] mc, input logic [31:0] a);
        match_code_i = mc; cpu_addr_i = a;
        #1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual running expected done");
            $display("  == %0d vectors applied, %0d miscompares ==", applied, miscompares);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R9 cleared bank: set0 hits with zero mask
        drive(8'h5A, 32'hDEAD_BEEF);
        check("R9 addr", xl_addr_o, 32'hDEAD_BEEF);
        check("R9 hit", {31'd0, hit_o}, 32'd1);
        check("R9 ctrl", {24'd0, ctrl_o}, 32'd0);
        // R10
        check("R10 count", {24'd0, set_count_o}, 32'd4);
        // R8 select 3 writes nothing
        wr(2'd0, 2'd3, 32'hFFFF_FFFF);
        drive(8'h5A, 32'hDEAD_BEEF);
        check("R8 sel3 hit", {31'd0, hit_o}, 32'd1);
        check("R8 sel3 addr", xl_addr_o, 32'hDEAD_BEEF);

        wr(2'd0, 2'd0, 32'hFFF0_000F); wr(2'd0, 2'd1, 32'h1230_0001); wr(2'd0, 2'd2, 32'hA000_0011);
        wr(2'd1, 2'd0, 32'hFF00_00F0); wr(2'd1, 2'd1, 32'h1200_0020); wr(2'd1, 2'd2, 32'h5500_0022);
        wr(2'd2, 2'd0, 32'h0000_00FF); wr(2'd2, 2'd1, 32'h0000_0077); wr(2'd2, 2'd2, 32'h0000_0133);
        wr(2'd3, 2'd0, 32'hF000_0000); wr(2'd3, 2'd1, 32'h7000_0000);

        // R8 timing of offset write on set3
        drive(8'h00, 32'h7123_4567);
        check("R8 before load", xl_addr_o, 32'h0123_4567);
        wr_en_i = 1'b1; wr_set_i = 2'd3; wr_sel_i = 2'd2; wr_data_i = 32'h0800_0044;
        #1;
        check("R8 held until edge", xl_addr_o, 32'h0123_4567);
        @(posedge clk); @(negedge clk);
        wr_en_i = 1'b0;
        check("R8 after edge", xl_addr_o, 32'h0923_4567);
        check("R4 after edge ctrl", {24'd0, ctrl_o}, 32'h44);

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][80:73], VEC[i][72:41]);
            check("R3 R5 R6 vector addr", xl_addr_o, VEC[i][40:9]);
            check("R6 vector hit", {31'd0, hit_o}, {31'd0, VEC[i][8]});
            check("R4 vector ctrl", {24'd0, ctrl_o}, {24'd0, VEC[i][7:0]});
            check("R7 low byte", {24'd0, xl_addr_o[7:0]}, {24'd0, VEC[i][48:41]});
            @(negedge clk);
        end

        // R9 reset again clears programmed bank
        do_reset();
        drive(8'h00, 32'h1234_5678);
        check("R9 re-reset hit", {31'd0, hit_o}, 32'd1);
        check("R9 re-reset addr", xl_addr_o, 32'h1234_5678);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", applied, miscompares);
        $finish;
    end
endmodule